// File: doc/BRIEF.md
# Programmable Repeating Loop-Code Detector

This block watches a received serial bit stream, one bit per accepted beat, for a repeating code that software has programmed. It has three independent detectors: index 0 for loop-up, index 1 for loop-down and index 2 for spare. Each detector has its own code bytes and its own length select. The supported lengths are 1 to 8 bits and 16 bits. The stream may arrive at any phase relative to the code, so each detector keeps one error counter for every alignment. At the end of each integration window of `WIN_BITS` counted bits, the detector decides whether any alignment stayed under `ERR_THR` errors. The default window is 74,112 bits, which is about 48 ms at 1.544 Mb/s. The default threshold is 2% of the window, which is above the 1% error rate that must still be accepted.

A flag on each beat marks framing-bit positions. The `fbit_ovw` input selects how those positions are treated. In insert mode (0) a flagged beat is dropped entirely. In overwrite mode (1) a flagged beat still advances the code phase but is left out of error counting and out of the window count.

The input stream uses valid/ready. `s_ready` is held at 1 at all times, so the block never applies back-pressure: a beat is accepted on every rising clock edge where `s_valid` is 1. A write port sets up the codes, the lengths, the interrupt enables, and the write-1-to-clear register for the latched bits.

Top module: `lpcode_det`

## Requirements
- R1: Length select is a 4-bit field. A value `v` below 8 selects a code of `v+1` bits taken from the low byte, and values 8 to 15 select 16 bits. For length L up to 8, the k-th received bit of a period is low-byte bit L-1-k. A clean repeat of the code seen for one full window, at any starting phase, sets the detector's real-time status on the edge that accepts the window's last counted bit. Real-time status changes only on an edge with a beat or a write.
- R2: For length 16 the code is {high byte, low byte}, and the k-th received bit is bit 15-k of that word.
- R3: A window in which the best alignment has fewer than `ERR_THR` mismatches counts as a match. Such a window sets real-time status or keeps it set.
- R4: A window in which every alignment has `ERR_THR` or more mismatches clears real-time status at the window's last edge.
- R5: In insert mode, a beat flagged by `s_fbit` does not advance the phase, the error counters or the window count.
- R6: In overwrite mode, a flagged beat advances the code phase but is excluded from the error counts and from the window count.
- R7: A write to a detector's low code byte clears that detector's window counter, error counters, phase and real-time status on the write edge.
- R8: Each detector has an on-latch and an off-latch. The on-latch sets one edge after real-time status rises. The off-latch sets one edge after real-time status falls, and this includes a fall caused by R7.
- R9: Writing to the acknowledge address clears each latch whose data bit is 1: bits 0 to 2 clear the on-latches and bits 3 to 5 clear the off-latches. A new set on the same edge wins over the clear.
- R10: `irq` is the OR of the latches whose enable bit is 1 in the mask register. The mask register uses the same bit positions as the acknowledge register, and it resets to 0.
- R11: Address map, per detector d: 4d holds the low byte, 4d+1 the high byte, 4d+2 the length select. Address 12 is the mask and address 13 is the acknowledge. After reset all outputs are 0 except `s_ready`, which stays at 1.
- R12: The three detectors judge the same stream independently. A detector whose code is absent does not set its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Beat present on the stream input |
| s_ready | output | 1 | Always 1; no back-pressure |
| s_data | input | 1 | Received bit |
| s_fbit | input | 1 | Beat is a framing-bit position |
| fbit_ovw | input | 1 | 0 = framing bits inserted, 1 = framing bits overwrite code bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Register write data |
| rt_status | output | NDET | Real-time detect status, one bit per detector |
| lat_on | output | NDET | Latched rise of real-time status |
| lat_off | output | NDET | Latched fall of real-time status |
| irq | output | 1 | Interrupt from enabled latches |

## Verification
Real-time status changes on the edge that accepts a window's final counted bit, or on the edge of a low-byte write. The latches follow one edge after that change, and `irq` follows the latches with no added delay. A write to the acknowledge or mask register acts on its own write edge. Each scoreboard item is therefore queued one falling edge after the last beat or write and compared on the falling edge after that, when both register stages have settled. The input is idle during that gap. The bench uses a short window so that boundary cases can be checked exactly: exactly `ERR_THR`-1 errors against `ERR_THR` errors, a restart one bit short of a window, and framing beats in both modes.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  localparam int MAX_LEN = 16;

  // 4-bit select -> code length in bits
  function automatic logic [4:0] sel_to_len(input logic [3:0] sel);
    return sel[3] ? 5'd16 : {2'b00, sel[2:0]} + 5'd1;
  endfunction

  // Expand the code bytes into a per-phase bit vector: bit k is the k-th bit of a period
  function automatic logic [MAX_LEN-1:0] code_bits(input logic [7:0] lo,
                                                   input logic [7:0] hi,
                                                   input logic [4:0] len);
    logic [15:0] word;
    logic [MAX_LEN-1:0] p;
    int idx;
    word = {hi, lo};
    p = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (len == 5'd16) begin
        p[k] = word[15-k];
      end else if (k < int'(len)) begin
        idx = int'(len) - 1 - k;
        p[k] = lo[idx[2:0]];
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/lpc_regs.sv
module lpc_regs #(
  parameter int NDET   = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        code_lo [NDET],
  output logic [7:0]        code_hi [NDET],
  output logic [3:0]        len_sel [NDET],
  output logic [NDET-1:0]   restart,
  output logic [2*NDET-1:0] irq_en,
  output logic [2*NDET-1:0] ack
);
  localparam int LW        = 2 * NDET;
  localparam int MASK_ADDR = 4 * NDET;
  localparam int ACK_ADDR  = 4 * NDET + 1;

  for (genvar d = 0; d < NDET; d++) begin : g_det
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(4 * d);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(4 * d + 1);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(4 * d + 2);

    assign restart[d] = wr_en && (wr_addr == A_LO);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_lo[d] <= '0;
        code_hi[d] <= '0;
        len_sel[d] <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_LO)  code_lo[d] <= wr_data;
        if (wr_addr == A_HI)  code_hi[d] <= wr_data;
        if (wr_addr == A_SEL) len_sel[d] <= wr_data[3:0];
      end
    end
  end

  assign ack = (wr_en && wr_addr == ADDR_W'(ACK_ADDR)) ? wr_data[LW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       irq_en <= '0;
    else if (wr_en && wr_addr == ADDR_W'(MASK_ADDR))  irq_en <= wr_data[LW-1:0];
  end

endmodule

// File: rtl/lpc_chan.sv
module lpc_chan
  import lpc_pkg::*;
#(
  parameter int WIN_BITS = 74112,
  parameter int ERR_THR  = WIN_BITS / 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               bit_in,
  input  logic               fbit,
  input  logic               ovw,
  input  logic               restart,
  input  logic [MAX_LEN-1:0] code,
  input  logic [4:0]         len,
  output logic               rt
);
  localparam int CW = $clog2(WIN_BITS + 1);

  logic [3:0]    ph, ph_eff, ph_nxt;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] err  [MAX_LEN];
  logic [CW-1:0] errn [MAX_LEN];
  logic          adv, cnt, last, hit;

  assign adv    = beat && !(fbit && !ovw);
  assign cnt    = beat && !fbit;
  assign last   = cnt && (wcnt == CW'(WIN_BITS - 1));
  assign ph_eff = ({1'b0, ph} < len) ? ph : 4'd0;
  assign ph_nxt = (({1'b0, ph_eff} + 5'd1) == len) ? 4'd0 : ph_eff + 4'd1;

  // one mismatch counter per alignment of the code against the stream
  always_comb begin
    logic [5:0] pos;
    hit = 1'b0;
    for (int a = 0; a < MAX_LEN; a++) begin
      pos = {2'b00, ph_eff} + 6'(a);
      if (pos >= {1'b0, len}) pos = pos - {1'b0, len};
      errn[a] = err[a] + CW'(cnt && (bit_in != code[pos[3:0]]));
      if ((5'(a) < len) && (errn[a] < CW'(ERR_THR))) hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      wcnt <= '0;
      rt   <= 1'b0;
      for (int a = 0; a < MAX_LEN; a++) err[a] <= '0;
    end else if (restart) begin
      ph   <= '0;
      wcnt <= '0;
      rt   <= 1'b0;
      for (int a = 0; a < MAX_LEN; a++) err[a] <= '0;
    end else begin
      if (adv) ph <= ph_nxt;
      if (cnt) begin
        if (last) begin
          wcnt <= '0;
          rt   <= hit;
          for (int a = 0; a < MAX_LEN; a++) err[a] <= '0;
        end else begin
          wcnt <= wcnt + CW'(1);
          for (int a = 0; a < MAX_LEN; a++) err[a] <= errn[a];
        end
      end
    end
  end

endmodule

// File: rtl/lpc_status.sv
module lpc_status #(
  parameter int NDET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDET-1:0]   rt,
  input  logic [2*NDET-1:0] ack,
  input  logic [2*NDET-1:0] irq_en,
  output logic [NDET-1:0]   lat_on,
  output logic [NDET-1:0]   lat_off,
  output logic              irq
);
  logic [NDET-1:0] rt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q    <= '0;
      lat_on  <= '0;
      lat_off <= '0;
    end else begin
      rt_q    <= rt;
      lat_on  <= (lat_on  & ~ack[NDET-1:0])      | (rt & ~rt_q);
      lat_off <= (lat_off & ~ack[2*NDET-1:NDET]) | (~rt & rt_q);
    end
  end

  assign irq = |({lat_off, lat_on} & irq_en);

endmodule

// File: rtl/lpcode_det.sv
module lpcode_det
  import lpc_pkg::*;
#(
  parameter int NDET     = 3,
  parameter int ADDR_W   = 4,
  parameter int WIN_BITS = 74112,
  parameter int ERR_THR  = WIN_BITS / 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_data,
  input  logic              s_fbit,
  input  logic              fbit_ovw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NDET-1:0]   rt_status,
  output logic [NDET-1:0]   lat_on,
  output logic [NDET-1:0]   lat_off,
  output logic              irq
);
  logic [7:0]        code_lo [NDET];
  logic [7:0]        code_hi [NDET];
  logic [3:0]        len_sel [NDET];
  logic [NDET-1:0]   restart;
  logic [2*NDET-1:0] irq_en, ack;
  logic              beat;

  assign s_ready = 1'b1;
  assign beat    = s_valid && s_ready;

  lpc_regs #(.NDET(NDET), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .code_lo(code_lo), .code_hi(code_hi), .len_sel(len_sel),
    .restart(restart), .irq_en(irq_en), .ack(ack)
  );

  for (genvar d = 0; d < NDET; d++) begin : g_chan
    logic [4:0]         len;
    logic [MAX_LEN-1:0] code;
    assign len  = sel_to_len(len_sel[d]);
    assign code = code_bits(code_lo[d], code_hi[d], len);

    lpc_chan #(.WIN_BITS(WIN_BITS), .ERR_THR(ERR_THR)) u_chan (
      .clk(clk), .rst_n(rst_n), .beat(beat), .bit_in(s_data), .fbit(s_fbit),
      .ovw(fbit_ovw), .restart(restart[d]), .code(code), .len(len),
      .rt(rt_status[d])
    );
  end

  lpc_status #(.NDET(NDET)) u_status (
    .clk(clk), .rst_n(rst_n), .rt(rt_status), .ack(ack), .irq_en(irq_en),
    .lat_on(lat_on), .lat_off(lat_off), .irq(irq)
  );

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int NDET   = 3,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [NDET-1:0]   rt_status,
  input logic [NDET-1:0]   lat_on,
  input logic [NDET-1:0]   lat_off,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(4 * NDET + 1);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n) s_ready);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !wr_en) |=> $stable(rt_status));

  p_no_latch_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_on == '0 && lat_off == '0) |-> !irq);

  for (genvar d = 0; d < NDET; d++) begin : g_d
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(4 * d)) |=> !rt_status[d]);

    p_rise_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rt_status[d]) |=> lat_on[d]);

    p_fall_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rt_status[d]) |=> lat_off[d]);

    p_ack_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ACK_A && wr_data[d] && !$rose(rt_status[d])) |=> !lat_on[d]);
  end

endmodule

bind lpcode_det lpc_checker #(.NDET(NDET), .ADDR_W(ADDR_W)) u_lpc_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rt_status(rt_status), .lat_on(lat_on), .lat_off(lat_off), .irq(irq)
);

// File: tb/test_lpcode_det.sv
module test_lpcode_det;
  localparam int NDET = 3;
  localparam int AW   = 4;
  localparam int WIN  = 96;
  localparam int THR  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_data = 1'b0, s_fbit = 1'b0, fbit_ovw = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic s_ready, irq;
  logic [NDET-1:0] rt_status, lat_on, lat_off;

  always #5 clk = ~clk;

  lpcode_det #(.NDET(NDET), .ADDR_W(AW), .WIN_BITS(WIN), .ERR_THR(THR)) i_lpcode_det (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_fbit(s_fbit), .fbit_ovw(fbit_ovw), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rt_status(rt_status), .lat_on(lat_on), .lat_off(lat_off), .irq(irq)
  );

  typedef struct {
    string    tag;
    logic [2:0] rt, on, off;
    logic     irq;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0, cycles = 0, bph = 0;
  bit done = 1'b0;

  function automatic logic pbit(input logic [15:0] pat, input int len, input int k);
    return pat[len-1-(k % len)];
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    s_valid = 1'b0; s_fbit = 1'b0;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic beat(input logic b, input logic f);
    @(negedge clk);
    s_valid = 1'b1; s_data = b; s_fbit = f;
  endtask

  // n counted bits of the code; framing beat before every fper-th counted bit
  task automatic send(input logic [15:0] pat, input int len, input int n,
                      input int nerr, input int fper, input bit ovw);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (fper > 0 && i > 0 && i % fper == 0) begin
        beat(~pbit(pat, len, bph), 1'b1);
        if (ovw) bph = (bph + 1) % len;
      end
      b = pbit(pat, len, bph);
      if ((i == 10 && nerr >= 1) || (i == 40 && nerr >= 2) || (i == 70 && nerr >= 3)) b = ~b;
      beat(b, 1'b0);
      bph = (bph + 1) % len;
    end
  endtask

  task automatic expect_out(input string tag, input logic [2:0] rt, input logic [2:0] on,
                            input logic [2:0] off, input logic ir);
    item_t it;
    @(negedge clk);
    s_valid = 1'b0; s_fbit = 1'b0;
    it.tag = tag; it.rt = rt; it.on = on; it.off = off; it.irq = ir;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  // monitor: compares one falling edge after the item is queued
  initial begin
    forever begin
      item_t it;
      wait (sb.size() > 0);
      @(negedge clk);
      it = sb[0];
      checks++;
      if (rt_status !== it.rt || lat_on !== it.on || lat_off !== it.off || irq !== it.irq) begin
        fails++;
        $display("FAIL %s: rt/on/off/irq actual %b/%b/%b/%b expected %b/%b/%b/%b", it.tag,
                 rt_status, lat_on, lat_off, irq, it.rt, it.on, it.off, it.irq);
      end
      void'(sb.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (s_ready !== 1'b1 || rt_status !== 3'b0 || lat_on !== 3'b0 || lat_off !== 3'b0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: actual %b %b %b %b %b expected 1 000 000 000 0",
               s_ready, rt_status, lat_on, lat_off, irq);
    end
    rst_n = 1'b1;
    // det0: 5-bit 10110, det1: 16-bit A53C, det2: 1-bit '1'
    wr(2, 4); wr(5, 8'hA5); wr(6, 8); wr(10, 0);
    wr(0, 8'h16); wr(4, 8'h3C); wr(8, 8'h01);

    bph = 2;
    send(16'h0016, 5, WIN, 0, 0, 0);
    expect_out("R1 R12 R8 clean window at phase 2", 3'b001, 3'b001, 3'b000, 1'b0);
    wr(12, 8'h01);
    expect_out("R10 enabled on-latch drives irq", 3'b001, 3'b001, 3'b000, 1'b1);
    wr(13, 8'h01);
    expect_out("R9 ack clears on-latch", 3'b001, 3'b000, 3'b000, 1'b0);

    send(16'h0016, 5, WIN, 2, 0, 0);
    expect_out("R3 THR-1 errors still match", 3'b001, 3'b000, 3'b000, 1'b0);
    send(16'h0016, 5, WIN, 3, 0, 0);
    expect_out("R4 THR errors clears status", 3'b000, 3'b000, 3'b001, 1'b0);
    wr(13, 8'h08);
    send(16'h0016, 5, WIN, 0, 0, 0);
    expect_out("R1 detect again", 3'b001, 3'b001, 3'b000, 1'b1);
    wr(13, 8'h01);

    send(16'h0016, 5, WIN / 2, 0, 0, 0);
    wr(0, 8'h16);
    expect_out("R7 low byte write clears status", 3'b000, 3'b000, 3'b001, 1'b0);
    wr(13, 8'h08);
    send(16'h0016, 5, WIN - 1, 0, 0, 0);
    expect_out("R7 window restarted, one bit short", 3'b000, 3'b000, 3'b000, 1'b0);
    send(16'h0016, 5, 1, 0, 0, 0);
    expect_out("R7 window completes after restart", 3'b001, 3'b001, 3'b000, 1'b1);
    wr(13, 8'h01);

    fbit_ovw = 1'b0;
    wr(0, 8'h16); wr(13, 8'h08);
    send(16'h0016, 5, WIN, 0, 7, 1'b0);
    expect_out("R5 insert mode framing beats skipped", 3'b001, 3'b001, 3'b000, 1'b1);

    fbit_ovw = 1'b1;
    wr(0, 8'h16); wr(13, 8'h09);
    send(16'h0016, 5, WIN, 0, 7, 1'b1);
    expect_out("R6 overwrite mode framing beats excluded", 3'b001, 3'b001, 3'b000, 1'b1);

    wr(0, 8'h16); wr(4, 8'h3C); wr(8, 8'h01); wr(13, 8'h3F);
    bph = 0;
    send(16'hA53C, 16, WIN, 0, 0, 0);
    expect_out("R2 R12 16-bit code on det1 only", 3'b010, 3'b010, 3'b000, 1'b0);

    wr(0, 8'h16); wr(4, 8'h3C); wr(8, 8'h01); wr(13, 8'h3F);
    bph = 0;
    send(16'h0001, 1, WIN, 0, 0, 0);
    expect_out("R1 R12 1-bit code on det2 only", 3'b100, 3'b100, 3'b000, 1'b0);

    wr(12, 8'h20); wr(13, 8'h3F);
    expect_out("R10 off-latch enabled, none set", 3'b100, 3'b000, 3'b000, 1'b0);
    wr(8, 8'h01);
    expect_out("R10 R8 restart sets enabled off-latch", 3'b000, 3'b000, 3'b100, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule